// File: doc/BRIEF.md
# Flash Self-Programming Sequencer

This block lets a processor rewrite its own program flash. Software first fills a 64-word row holding buffer through single-word table writes. These must come in strict ascending order inside one 64-word-aligned group. Software then sets the target address for a word write or a page erase, picks the operation in a control register, and writes a two-value key. Setting the start bit then launches the operation.

While an operation runs, the block holds the processor in a stall. It drives a behavioural flash-array interface with a timed command and its data. When the time is up, it clears the start bit and pulses a completion strobe for one cycle. Any attempt that breaks the unlock, the operation encoding or the buffer-ordering rules is refused, and a sticky error bit is raised instead.

Registers are written through a small write port. `reg_sel` picks the register: 0 is control, 1 is key, 2 is target address, and 3 is an unused slot. Writes to the unused slot still count as bus writes.

Top module: `nvm_prog_seq`

## Requirements
- R1: After reset, `ctrl_rdata` reads 0x0000, `cpu_stall` and `op_done` are 0, and `tw_ready` is 1.
- R2: The controller arms only when a key write of 0x0055 is followed by a key write of 0x00AA, with no other register write or accepted table write between them. Any other value or any intervening write returns the lock to idle.
- R3: A start (control bit 15 written as 1) while not armed launches nothing, leaves `cpu_stall` at 0 and sets the error bit (control bit 13). Writing the control register with bit 13 at 0 clears that bit.
- R4: Every start attempt made while armed uses up the unlock, so a second start needs a new key sequence.
- R5: A buffer load must begin at offset 0 of a 64-word-aligned group, and each later load must hit the next word address. A load that breaks this rule, or that goes past 64 words, sets the error bit at once. A row write whose buffer is not a complete, error-free 64 words is refused with the error bit set, and every armed start attempt empties the buffer.
- R6: An accepted table write drops `tw_ready` for the following cycle, and `tw_valid` during that cycle is ignored. `tw_ready` is also 0 while `cpu_stall` is 1.
- R7: A row write is selected by control bits {6, 1:0} = {0, 01}. It holds `cpu_stall` for ROW_CYC cycles. During the first 64 of those cycles it asserts `fl_prog` with `fl_addr` equal to the group base plus i and `fl_wdata` equal to buffered word i.
- R8: A word write is selected by {0, 00}. It holds `cpu_stall` for WORD_CYC cycles and asserts `fl_prog` once, in the first busy cycle, with the target address and buffered word 0.
- R9: A page erase is selected by {1, 10}. It holds `cpu_stall` for PAGE_CYC cycles and asserts `fl_erase` once, in the first busy cycle, with the target address cleared in its low 9 bits. `fl_prog` and `fl_erase` are never both high.
- R10: In the cycle after the last busy cycle, control bit 15 reads 0 and `op_done` is 1 for exactly one cycle.
- R11: Any other combination of control bits {6, 1:0} with a start is refused with the error bit set. Bits 6 and 1:0 read back as they were last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 key, 2 target address, 3 unused |
| reg_wdata | input | 16 | Register write data |
| ctrl_rdata | output | 16 | Control register: 15 start/busy, 13 error, 6 erase, 1:0 size |
| tw_valid | input | 1 | Table-write request into the row buffer |
| tw_addr | input | ADDR_W | Word address of the table write |
| tw_data | input | DATA_W | Instruction word of the table write |
| tw_ready | output | 1 | Table write can be accepted this cycle |
| cpu_stall | output | 1 | Operation in progress, processor held |
| op_done | output | 1 | One-cycle completion strobe |
| fl_prog | output | 1 | Array program command for one word |
| fl_erase | output | 1 | Array page-erase command |
| fl_addr | output | ADDR_W | Array word address for the command |
| fl_wdata | output | DATA_W | Data word for a program command |

## Verification
The hardest state to reach is a row write refused by the buffer rules rather than by the lock. The block has to be properly armed, yet hold a buffer that is either poisoned by an out-of-order load or only partly filled. The stimulus builds both cases on purpose. It makes one bad load followed by a cleared error bit, and a short run of ten good loads, each followed by a valid unlock and a row start. It then proves that the refused attempts emptied the buffer: a fresh full row in a different group is written, and every word is checked by the scoreboard.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;

   typedef enum logic [1:0] {
      OP_WORD = 2'b00,
      OP_ROW  = 2'b01,
      OP_PAGE = 2'b10,
      OP_NONE = 2'b11
   } op_kind_e;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'b00,
      SEL_KEY  = 2'b01,
      SEL_ADDR = 2'b10,
      SEL_RSVD = 2'b11
   } reg_sel_e;

   typedef enum logic [1:0] {
      K_IDLE  = 2'b00,
      K_HALF  = 2'b01,
      K_ARMED = 2'b10
   } key_state_e;

   localparam logic [15:0] KEY_FIRST  = 16'h0055;
   localparam logic [15:0] KEY_SECOND = 16'h00AA;

   localparam int CTRL_START = 15;
   localparam int CTRL_ERR   = 13;
   localparam int CTRL_ERASE = 6;

   // Maps the erase bit and size field to an operation; unsupported pairs give OP_NONE.
   function automatic op_kind_e decode_op(input logic erase, input logic [1:0] size);
      if (!erase && size == 2'b00)     return OP_WORD;
      else if (!erase && size == 2'b01) return OP_ROW;
      else if (erase && size == 2'b10)  return OP_PAGE;
      else                              return OP_NONE;
   endfunction

endpackage

// File: rtl/nvm_key_lock.sv
module nvm_key_lock
   import nvm_prog_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        any_wr,
   input  logic        key_wr,
   input  logic [15:0] key_val,
   input  logic        consume,
   output logic        armed
);

   key_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= K_IDLE;
      end else if (consume) begin
         state_q <= K_IDLE;
      end else if (any_wr) begin
         unique case (state_q)
            K_IDLE:  state_q <= (key_wr && key_val == KEY_FIRST) ? K_HALF : K_IDLE;
            K_HALF:  state_q <= (key_wr && key_val == KEY_SECOND) ? K_ARMED : K_IDLE;
            K_ARMED: state_q <= K_ARMED;
            default: state_q <= K_IDLE;
         endcase
      end
   end

   assign armed = (state_q == K_ARMED);

   AST_ARM_NEEDS_SECOND_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(key_wr && key_val == KEY_SECOND)); // R2

   AST_HALF_NEEDS_FIRST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == K_HALF && $past(state_q) == K_IDLE) |-> $past(key_wr && key_val == KEY_FIRST)); // R2

endmodule

// File: rtl/nvm_row_buffer.sv
module nvm_row_buffer #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 24,
   parameter int ROW_LG2 = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld,
   input  logic [ADDR_W-1:0]    ld_addr,
   input  logic [DATA_W-1:0]    ld_data,
   input  logic                 clr,
   input  logic [ROW_LG2-1:0]   rd_idx,
   output logic [DATA_W-1:0]    rd_data,
   output logic [ADDR_W-1:0]    grp_base,
   output logic                 full_ok,
   output logic                 ld_err
);

   localparam int ROW_WORDS = 1 << ROW_LG2;
   localparam int CNT_W     = ROW_LG2 + 1;
   localparam int GRP_W     = ADDR_W - ROW_LG2;

   logic [CNT_W-1:0]  cnt_q;
   logic [GRP_W-1:0]  grp_q;
   logic              seq_err_q;
   logic [DATA_W-1:0] mem [ROW_WORDS];
   logic              in_order;
   logic              take;

   always_comb begin
      if (cnt_q == '0)
         in_order = (ld_addr[ROW_LG2-1:0] == '0);
      else
         in_order = (cnt_q != CNT_W'(ROW_WORDS)) &&
                    (ld_addr == {grp_q, cnt_q[ROW_LG2-1:0]});
   end

   assign take   = ld && !clr && !seq_err_q && in_order;
   assign ld_err = ld && !clr && !in_order;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         grp_q     <= '0;
         seq_err_q <= 1'b0;
      end else if (clr) begin
         cnt_q     <= '0;
         seq_err_q <= 1'b0;
      end else if (take) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == '0) grp_q <= ld_addr[ADDR_W-1:ROW_LG2];
      end else if (ld_err) begin
         seq_err_q <= 1'b1;
      end
   end

   for (genvar gi = 0; gi < ROW_WORDS; gi++) begin : g_slot
      always_ff @(posedge clk) begin
         if (take && !cnt_q[ROW_LG2] && cnt_q[ROW_LG2-1:0] == ROW_LG2'(gi))
            mem[gi] <= ld_data;
      end
   end

   assign rd_data  = mem[rd_idx];
   assign grp_base = {grp_q, {ROW_LG2{1'b0}}};
   assign full_ok  = (cnt_q == CNT_W'(ROW_WORDS)) && !seq_err_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(ROW_WORDS)); // R5

   AST_ERR_FREEZES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_err_q && !clr) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer
   import nvm_prog_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int ROW_LG2  = 6,
   parameter int PAGE_LG2 = 9,
   parameter int ROW_CYC  = 11064,
   parameter int WORD_CYC = 355,
   parameter int PAGE_CYC = 168517
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  op_kind_e            go_kind,
   input  logic [ADDR_W-1:0]   go_addr,
   output logic                busy,
   output logic                done,
   output logic                fl_prog,
   output logic                fl_erase,
   output logic [ADDR_W-1:0]   fl_addr,
   output logic [ROW_LG2-1:0]  rd_idx
);

   localparam int ROW_WORDS = 1 << ROW_LG2;
   localparam int MAX_RW    = (ROW_CYC > WORD_CYC) ? ROW_CYC : WORD_CYC;
   localparam int MAX_CYC   = (MAX_RW > PAGE_CYC) ? MAX_RW : PAGE_CYC;
   localparam int CNT_W     = $clog2(MAX_CYC + 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  last_cnt;
   op_kind_e          kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic              row_phase;

   always_comb begin
      unique case (kind_q)
         OP_ROW:  last_cnt = CNT_W'(ROW_CYC - 1);
         OP_PAGE: last_cnt = CNT_W'(PAGE_CYC - 1);
         default: last_cnt = CNT_W'(WORD_CYC - 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         cnt_q  <= '0;
         kind_q <= OP_NONE;
         addr_q <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (go) begin
               busy   <= 1'b1;
               cnt_q  <= '0;
               kind_q <= go_kind;
               addr_q <= go_addr;
            end
         end else if (cnt_q == last_cnt) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign row_phase = busy && kind_q == OP_ROW && cnt_q < CNT_W'(ROW_WORDS);
   assign rd_idx    = (kind_q == OP_ROW) ? cnt_q[ROW_LG2-1:0] : '0;
   assign fl_prog   = row_phase || (busy && kind_q == OP_WORD && cnt_q == '0);
   assign fl_erase  = busy && kind_q == OP_PAGE && cnt_q == '0;

   always_comb begin
      unique case (kind_q)
         OP_ROW:  fl_addr = {addr_q[ADDR_W-1:ROW_LG2], rd_idx};
         OP_PAGE: fl_addr = {addr_q[ADDR_W-1:PAGE_LG2], {PAGE_LG2{1'b0}}};
         default: fl_addr = addr_q;
      endcase
   end

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R10

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

   AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_prog && fl_erase)); // R9

   AST_ERASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      fl_erase |-> (fl_addr[PAGE_LG2-1:0] == '0)); // R9

endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
   import nvm_prog_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 24,
   parameter int ROW_LG2       = 6,
   parameter int ROWS_PER_PAGE = 8,
   parameter int ROW_CYC       = 11064,
   parameter int WORD_CYC      = 355,
   parameter int PAGE_CYC      = 168517
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       ctrl_rdata,
   input  logic              tw_valid,
   input  logic [ADDR_W-1:0] tw_addr,
   input  logic [DATA_W-1:0] tw_data,
   output logic              tw_ready,
   output logic              cpu_stall,
   output logic              op_done,
   output logic              fl_prog,
   output logic              fl_erase,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [DATA_W-1:0] fl_wdata
);

   localparam int ROW_WORDS = 1 << ROW_LG2;
   localparam int PAGE_LG2  = ROW_LG2 + $clog2(ROWS_PER_PAGE);

   if (ROWS_PER_PAGE != (1 << $clog2(ROWS_PER_PAGE))) begin : g_bad_page
      $error("ROWS_PER_PAGE must be a power of two");
   end
   if (ADDR_W > 16 || ADDR_W <= PAGE_LG2) begin : g_bad_addr
      $error("ADDR_W must exceed the page offset width and fit the register port");
   end
   if (ROW_CYC < ROW_WORDS) begin : g_bad_row
      $error("ROW_CYC must cover one cycle per buffered word");
   end
   if (WORD_CYC < 1 || PAGE_CYC < 1) begin : g_bad_cyc
      $error("operation lengths must be at least one cycle");
   end

   logic              busy;
   logic              tw_hold_q;
   logic              tw_acc;
   logic              wr_ok;
   logic              ctrl_wr;
   logic              key_wr;
   logic              addr_wr;
   logic              start_req;
   logic              armed;
   logic              consume;
   logic              go;
   op_kind_e          req_kind;
   logic              row_blocked;
   logic              ld_err;
   logic              buf_full;
   logic [ADDR_W-1:0] grp_base;
   logic [ADDR_W-1:0] tgt_addr_q;
   logic [ADDR_W-1:0] go_addr;
   logic [ROW_LG2-1:0] rd_idx;
   logic              erase_q;
   logic [1:0]        size_q;
   logic              err_q;

   assign tw_ready  = !tw_hold_q && !busy;
   assign tw_acc    = tw_valid && tw_ready;
   assign wr_ok     = reg_we && !busy;
   assign ctrl_wr   = wr_ok && reg_sel_e'(reg_sel) == SEL_CTRL;
   assign key_wr    = wr_ok && reg_sel_e'(reg_sel) == SEL_KEY;
   assign addr_wr   = wr_ok && reg_sel_e'(reg_sel) == SEL_ADDR;
   assign start_req = ctrl_wr && reg_wdata[CTRL_START];

   assign req_kind    = decode_op(reg_wdata[CTRL_ERASE], reg_wdata[1:0]);
   assign row_blocked = (req_kind == OP_ROW) && !buf_full;
   assign consume     = start_req && armed;
   assign go          = consume && req_kind != OP_NONE && !row_blocked;
   assign go_addr     = (req_kind == OP_ROW) ? grp_base : tgt_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tw_hold_q  <= 1'b0;
         tgt_addr_q <= '0;
         erase_q    <= 1'b0;
         size_q     <= 2'b00;
         err_q      <= 1'b0;
      end else begin
         tw_hold_q <= tw_acc;
         if (addr_wr) tgt_addr_q <= reg_wdata[ADDR_W-1:0];
         if (ctrl_wr) begin
            erase_q <= reg_wdata[CTRL_ERASE];
            size_q  <= reg_wdata[1:0];
         end
         if ((start_req && !go) || ld_err)
            err_q <= 1'b1;
         else if (ctrl_wr && !reg_wdata[CTRL_ERR])
            err_q <= 1'b0;
      end
   end

   nvm_key_lock u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .any_wr  (wr_ok || tw_acc),
      .key_wr  (key_wr),
      .key_val (reg_wdata),
      .consume (consume),
      .armed   (armed)
   );

   nvm_row_buffer #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .ROW_LG2 (ROW_LG2)
   ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (tw_acc),
      .ld_addr  (tw_addr),
      .ld_data  (tw_data),
      .clr      (consume),
      .rd_idx   (rd_idx),
      .rd_data  (fl_wdata),
      .grp_base (grp_base),
      .full_ok  (buf_full),
      .ld_err   (ld_err)
   );

   nvm_op_timer #(
      .ADDR_W   (ADDR_W),
      .ROW_LG2  (ROW_LG2),
      .PAGE_LG2 (PAGE_LG2),
      .ROW_CYC  (ROW_CYC),
      .WORD_CYC (WORD_CYC),
      .PAGE_CYC (PAGE_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .go_kind  (req_kind),
      .go_addr  (go_addr),
      .busy     (busy),
      .done     (op_done),
      .fl_prog  (fl_prog),
      .fl_erase (fl_erase),
      .fl_addr  (fl_addr),
      .rd_idx   (rd_idx)
   );

   assign cpu_stall  = busy;
   assign ctrl_rdata = {busy, 1'b0, err_q, 6'b0, erase_q, 4'b0, size_q};

   AST_GO_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> armed); // R2

   AST_KEY_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      consume |=> !armed); // R4

   AST_TW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tw_acc |=> !tw_ready); // R6

   AST_REFUSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !go) |=> (err_q && !cpu_stall)); // R3

endmodule

// File: tb/tb_nvm_prog_seq.sv
module tb_nvm_prog_seq;

   localparam int ADDR_W   = 16;
   localparam int DATA_W   = 24;
   localparam int ROW_CYC  = 100;
   localparam int WORD_CYC = 20;
   localparam int PAGE_CYC = 150;

   typedef struct {
      bit                erase;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
   } fl_item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_we = 1'b0;
   logic [1:0]        reg_sel = 2'b00;
   logic [15:0]       reg_wdata = '0;
   logic [15:0]       ctrl_rdata;
   logic              tw_valid = 1'b0;
   logic [ADDR_W-1:0] tw_addr = '0;
   logic [DATA_W-1:0] tw_data = '0;
   logic              tw_ready;
   logic              cpu_stall;
   logic              op_done;
   logic              fl_prog;
   logic              fl_erase;
   logic [ADDR_W-1:0] fl_addr;
   logic [DATA_W-1:0] fl_wdata;

   int n_chk = 0;
   int n_bad = 0;
   fl_item_t exp_q[$];

   always #5 clk = ~clk;

   nvm_prog_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_CYC(ROW_CYC),
      .WORD_CYC(WORD_CYC), .PAGE_CYC(PAGE_CYC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .tw_valid(tw_valid),
      .tw_addr(tw_addr), .tw_data(tw_data), .tw_ready(tw_ready),
      .cpu_stall(cpu_stall), .op_done(op_done), .fl_prog(fl_prog),
      .fl_erase(fl_erase), .fl_addr(fl_addr), .fl_wdata(fl_wdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // Monitor: each flash command is compared with the head of the scoreboard queue.
   always @(negedge clk) begin
      if (rst_n && (fl_prog || fl_erase)) begin
         if (exp_q.size() == 0) begin
            chk("R7 unexpected flash command", {15'd0, fl_erase, fl_addr}, 32'hFFFF_FFFF);
         end else begin
            fl_item_t it;
            it = exp_q.pop_front();
            chk("R9 command kind", {31'd0, fl_erase}, {31'd0, it.erase});
            chk("R7 flash address", {16'd0, fl_addr}, {16'd0, it.addr});
            if (!it.erase) chk("R8 flash data", {8'd0, fl_wdata}, {8'd0, it.data});
         end
      end
   end

   task automatic reg_wr(input logic [1:0] sel, input logic [15:0] val);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic unlock();
      reg_wr(2'd1, 16'h0055);
      reg_wr(2'd1, 16'h00AA);
   endtask

   task automatic tw_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input bit probe);
      @(negedge clk);
      while (!tw_ready) @(negedge clk);
      tw_valid = 1'b1; tw_addr = a; tw_data = d;
      @(negedge clk);
      if (probe) begin
         chk("R6 ready low after accept", {31'd0, tw_ready}, 32'd0);
         tw_addr = a + 16'd7;
         @(negedge clk);
      end
      tw_valid = 1'b0;
   endtask

   function automatic logic [DATA_W-1:0] pat(input int g, input int i);
      return DATA_W'(32'h00A5_0000 ^ (g * 32'h0001_0300) ^ (i * 32'h0000_0107));
   endfunction

   task automatic load_row(input int g, input bit push);
      for (int i = 0; i < 64; i++) begin
         tw_wr(ADDR_W'(g * 64 + i), pat(g, i), (i == 5));
         if (push) exp_q.push_back('{1'b0, ADDR_W'(g * 64 + i), pat(g, i)});
      end
   endtask

   task automatic run_ok(input logic [15:0] cval, input int len, input string req);
      int n = 0;
      reg_wr(2'd0, cval);
      while (cpu_stall && n < 100000) begin n++; @(negedge clk); end
      chk(req, n, len);
      chk("R10 done pulse", {31'd0, op_done}, 32'd1);
      chk("R10 start cleared", {31'd0, ctrl_rdata[15]}, 32'd0);
      @(negedge clk);
      chk("R10 done one cycle", {31'd0, op_done}, 32'd0);
      chk("R7 scoreboard drained", exp_q.size(), 32'd0);
      chk("R3 no error after good op", {31'd0, ctrl_rdata[13]}, 32'd0);
   endtask

   task automatic run_refused(input logic [15:0] cval, input string req);
      reg_wr(2'd0, cval);
      chk({req, " no stall"}, {31'd0, cpu_stall}, 32'd0);
      chk({req, " error set"}, {31'd0, ctrl_rdata[13]}, 32'd1);
      reg_wr(2'd0, 16'h0000);
      chk("R3 error cleared", {31'd0, ctrl_rdata[13]}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk("watchdog expired", 32'd1, 32'd0);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ctrl reset", {16'd0, ctrl_rdata}, 32'd0);
      chk("R1 stall reset", {31'd0, cpu_stall}, 32'd0);
      chk("R1 done reset", {31'd0, op_done}, 32'd0);
      chk("R1 ready reset", {31'd0, tw_ready}, 32'd1);

      // R7: full row in group 5, with an ignored probe during a hold cycle (R6)
      load_row(5, 1'b1);
      chk("R6 probe ignored", {31'd0, ctrl_rdata[13]}, 32'd0);
      unlock();
      run_ok(16'h8001, ROW_CYC, "R7 row busy length");

      // R3: start with no unlock
      run_refused(16'h8001, "R3 locked start");

      // R2: intervening write, wrong second key, intervening table write
      tw_wr(16'h0280, 24'h13579B, 1'b0);
      reg_wr(2'd1, 16'h0055); reg_wr(2'd2, 16'h1234); reg_wr(2'd1, 16'h00AA);
      run_refused(16'h8000, "R2 broken by other write");
      reg_wr(2'd1, 16'h0055); reg_wr(2'd1, 16'h00AB);
      run_refused(16'h8000, "R2 wrong key");
      reg_wr(2'd1, 16'h0055); tw_wr(16'h0281, 24'h000001, 1'b0); reg_wr(2'd1, 16'h00AA);
      run_refused(16'h8000, "R2 broken by table write");
      reg_wr(2'd0, 16'h0000);

      // R8: word write of buffered word 0 to the target address
      reg_wr(2'd2, 16'h1234);
      unlock();
      exp_q.push_back('{1'b0, 16'h1234, 24'h13579B});
      run_ok(16'h8000, WORD_CYC, "R8 word busy length");

      // R4: unlock used up by the previous start
      run_refused(16'h8000, "R4 reuse of unlock");

      // R9: page erase, low 9 address bits cleared
      reg_wr(2'd2, 16'h1357);
      unlock();
      exp_q.push_back('{1'b1, 16'h1200, '0});
      run_ok(16'h8042, PAGE_CYC, "R9 page busy length");

      // R11: unsupported combination, and field readback
      unlock();
      run_refused(16'h8002, "R11 program+page");
      reg_wr(2'd0, 16'h0041);
      chk("R11 field readback", {16'd0, ctrl_rdata}, 32'h0041);
      reg_wr(2'd0, 16'h0000);

      // R5: out-of-order load then armed row start
      tw_wr(16'h00C0, 24'h111111, 1'b0);
      tw_wr(16'h00C2, 24'h222222, 1'b0);
      chk("R5 order error flag", {31'd0, ctrl_rdata[13]}, 32'd1);
      reg_wr(2'd0, 16'h0000);
      unlock();
      run_refused(16'h8001, "R5 poisoned row");
      // R5: partial buffer
      for (int i = 0; i < 10; i++) tw_wr(ADDR_W'(128 + i), pat(2, i), 1'b0);
      unlock();
      run_refused(16'h8001, "R5 partial row");
      // R5: buffer emptied by refusals, a fresh row in group 7 succeeds
      load_row(7, 1'b1);
      unlock();
      run_ok(16'h8001, ROW_CYC, "R5 row after refusals");
      // R5: load beyond group end
      load_row(9, 1'b0);
      tw_wr(ADDR_W'(9 * 64 + 64), 24'h0, 1'b0);
      chk("R5 overflow error", {31'd0, ctrl_rdata[13]}, 32'd1);

      summary();
   end

endmodule